// File: doc/BRIEF.md
# Radix-2 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of width N over several clock cycles and returns their signed 2N-bit product. It keeps one working register made of an upper half, a lower half and one extra bit below the lower half. At the start the lower half holds the multiplier, and the upper half and the extra bit are cleared. The multiplicand is captured once in its own register and is held there for the whole operation.

On every step the block looks at the lowest bit of the lower half and at the extra bit, which holds the bit shifted out in the step before. This pair marks where a run of ones begins or ends. Depending on the pair, the block adds the multiplicand to the upper half, subtracts it, or leaves the upper half as it is. It then shifts the whole register right by one place and keeps the sign. Negative multipliers therefore need no separate correction. After N steps a single-cycle done pulse marks the result as valid, and the result stays on the output until the next operation is accepted.

Top module: `booth_mul_top`

## Requirements
- R1: While reset is high, and after it is released with no start seen, `done` is 0 and `product` is 0.
- R2: A `start` sampled while idle loads the working register: the upper half becomes 0, the lower half takes `multiplier`, and the extra bit becomes 0.
- R3: When the lowest lower-half bit and the extra bit are both 0, or both 1, the upper half takes no arithmetic change in that step.
- R4: When the lowest lower-half bit is 0 and the extra bit is 1, the multiplicand is added to the upper half before the shift.
- R5: When the lowest lower-half bit is 1 and the extra bit is 0, the multiplicand is subtracted from the upper half before the shift.
- R6: Every step ends with an arithmetic right shift of the whole register. The sign of the add/subtract result, computed one bit wider than the upper half, fills the vacated top position, and the bit that leaves the lower half becomes the new extra bit.
- R7: `done` is high for exactly one cycle. It rises on the N-th clock edge after the edge that sampled the accepted `start`.
- R8: When `done` is high, and afterwards until the next accepted `start`, `product` equals the signed product of the operands. This includes the most negative value times itself.
- R9: A `start` pulse that arrives while an operation is in progress is ignored and does not change the result of that operation.
- R10: The multiplicand register does not change while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | N | Signed multiplicand, sampled with `start` |
| multiplier | input | N | Signed multiplier, sampled with `start` |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2N | Signed product, upper half then lower half |

## Verification
The hardest case to reach is the most negative multiplicand times the most negative multiplier. In that case the upper-half subtraction overflows N bits, and the result is correct only if the one-bit sign extension inside the step works. The stimulus applies this pair directly at both widths. It also runs every operand pair at N=4, so that every run-of-ones pattern is applied, including multipliers whose top bit starts a run that never ends. A second start pulse in the middle of an operation checks that a busy block ignores it.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        BOP_KEEP = 2'd0,
        BOP_ADD  = 2'd1,
        BOP_SUB  = 2'd2
    } booth_op_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Pair (current lower bit, previous shifted-out bit) selects the action.
    function automatic booth_op_e booth_recode(input logic cur, input logic prev);
        case ({cur, prev})
            2'b01:   return BOP_ADD;
            2'b10:   return BOP_SUB;
            default: return BOP_KEEP;
        endcase
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_e op
);
    always_comb op = booth_recode(cur_bit, prev_bit);
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] upper,
    input  logic [N-1:0] mcand,
    input  booth_op_e    op,
    output logic [N:0]   result
);
    localparam int XW = N + 1;

    logic [XW-1:0] upper_x;
    logic [XW-1:0] mcand_x;

    always_comb begin
        upper_x = {upper[N-1], upper};
        mcand_x = {mcand[N-1], mcand};
        case (op)
            BOP_ADD: result = upper_x + mcand_x;
            BOP_SUB: result = upper_x - mcand_x;
            default: result = upper_x;
        endcase
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(N + 1);

    seq_state_e    state_q;
    logic [CW-1:0] left_q;

    assign busy = (state_q == SEQ_RUN);
    assign load = start && !busy;
    assign step = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            left_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state_q <= SEQ_RUN;
                left_q  <= CW'(N);
            end else if (step) begin
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) begin
                    state_q <= SEQ_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/booth_mul_top.sv
module booth_mul_top
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N-1:0]     multiplicand,
    input  logic [N-1:0]     multiplier,
    output logic             done,
    output logic [2*N-1:0]   product
);
    logic          load;
    logic          step;
    logic          busy_q;
    logic [N-1:0]  acc_hi;
    logic [N-1:0]  acc_lo;
    logic          acc_prev;
    logic [N-1:0]  mcand_q;
    logic [N:0]    sum_x;
    booth_op_e     op;

    booth_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy_q),
        .done  (done)
    );

    booth_recoder u_recode (
        .cur_bit  (acc_lo[0]),
        .prev_bit (acc_prev),
        .op       (op)
    );

    booth_addsub #(.N(N)) u_addsub (
        .upper  (acc_hi),
        .mcand  (mcand_q),
        .op     (op),
        .result (sum_x)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi   <= '0;
            acc_lo   <= '0;
            acc_prev <= 1'b0;
            mcand_q  <= '0;
        end else if (load) begin
            acc_hi   <= '0;
            acc_lo   <= multiplier;
            acc_prev <= 1'b0;
            mcand_q  <= multiplicand;
        end else if (step) begin
            // arithmetic shift of {sum, lower, prev} by one place
            acc_hi   <= sum_x[N:1];
            acc_lo   <= {sum_x[0], acc_lo[N-1:1]};
            acc_prev <= acc_lo[0];
        end
    end

    assign product = {acc_hi, acc_lo};
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [N-1:0]  hi,
    input logic [N-1:0]  lo,
    input logic          prev,
    input logic [N-1:0]  mcand,
    input booth_op_e     op
);
    localparam int SW = $clog2(N + 1) + 1;

    logic [SW-1:0] steps_seen;

    always_ff @(posedge clk) begin
        if (rst)                steps_seen <= '0;
        else if (start && !busy) steps_seen <= '0;
        else if (busy)          steps_seen <= steps_seen + 1'b1;
    end

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (hi == '0 && prev == 1'b0)); // R2

    AST_KEEP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (busy && op == BOP_KEEP) |=> (hi == $past({hi[N-1], hi[N-1:1]}))); // R3

    AST_ADD_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && op == BOP_ADD) |=> ({hi, lo[N-1]} == $past({hi[N-1], hi} + {mcand[N-1], mcand}))); // R4

    AST_SUB_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && op == BOP_SUB) |=> ({hi, lo[N-1]} == $past({hi[N-1], hi} - {mcand[N-1], mcand}))); // R5

    AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        busy |=> (prev == $past(lo[0]))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_AFTER_N: assert property (@(posedge clk) disable iff (rst)
        done |-> (steps_seen == SW'(N))); // R7

    AST_MCAND_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> $stable(mcand)); // R10

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (busy && start && steps_seen != SW'(N - 1)) |=> busy); // R9
endmodule

bind booth_mul_top booth_mul_chk #(.N(N)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy_q),
    .done  (done),
    .hi    (acc_hi),
    .lo    (acc_lo),
    .prev  (acc_prev),
    .mcand (mcand_q),
    .op    (op)
);

// File: tb/test_booth_mul_top.sv
`timescale 1ns/1ps
module test_booth_mul_top;
    localparam int NW = 32;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [NW-1:0] a32 = '0, b32 = '0;
    logic [NS-1:0] a4 = '0, b4 = '0;
    logic done32, done4;
    logic [2*NW-1:0] prod32;
    logic [2*NS-1:0] prod4;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    booth_mul_top #(.N(NW)) i_booth_mul_top (
        .clk(clk), .rst(rst), .start(start),
        .multiplicand(a32), .multiplier(b32),
        .done(done32), .product(prod32)
    );

    booth_mul_top #(.N(NS)) i_booth_mul_top_n4 (
        .clk(clk), .rst(rst), .start(start),
        .multiplicand(a4), .multiplier(b4),
        .done(done4), .product(prod4)
    );

    // behavioural reference: timing by countdown, value by signed multiply
    logic m32_busy, m4_busy, m32_done, m4_done;
    int   m32_cnt, m4_cnt;
    logic signed [2*NW-1:0] m32_res, m32_prod;
    logic signed [2*NS-1:0] m4_res, m4_prod;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m32_busy <= 0; m32_cnt <= 0; m32_done <= 0; m32_prod <= '0; m32_res <= '0;
            m4_busy  <= 0; m4_cnt  <= 0; m4_done  <= 0; m4_prod  <= '0; m4_res  <= '0;
        end else begin
            m32_done <= 0;
            m4_done  <= 0;
            if (start && !m32_busy) begin
                m32_busy <= 1; m32_cnt <= NW;
                m32_res  <= 64'(longint'($signed(a32)) * longint'($signed(b32)));
            end else if (m32_busy) begin
                m32_cnt <= m32_cnt - 1;
                if (m32_cnt == 1) begin m32_busy <= 0; m32_done <= 1; m32_prod <= m32_res; end
            end
            if (start && !m4_busy) begin
                m4_busy <= 1; m4_cnt <= NS;
                m4_res  <= 8'(int'($signed(a4)) * int'($signed(b4)));
            end else if (m4_busy) begin
                m4_cnt <= m4_cnt - 1;
                if (m4_cnt == 1) begin m4_busy <= 0; m4_done <= 1; m4_prod <= m4_res; end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cyc >= 1) begin
            vectors += 2;
            if (done32 !== m32_done) begin
                fails++;
                $display("FAIL R7 (%s) N=32 done: actual %0b expected %0b", cur_req, done32, m32_done);
            end
            if (done4 !== m4_done) begin
                fails++;
                $display("FAIL R7 (%s) N=4 done: actual %0b expected %0b", cur_req, done4, m4_done);
            end
            if (!m32_busy) begin
                vectors++;
                if (prod32 !== m32_prod) begin
                    fails++;
                    $display("FAIL R8 (%s) N=32 product: actual %h expected %h", cur_req, prod32, m32_prod);
                end
            end
            if (!m4_busy) begin
                vectors++;
                if (prod4 !== m4_prod) begin
                    fails++;
                    $display("FAIL R8 (%s) N=4 product: actual %h expected %h", cur_req, prod4, m4_prod);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    task automatic run_op(input logic [NS-1:0] x4, input logic [NS-1:0] y4,
                          input logic [NW-1:0] x32, input logic [NW-1:0] y32,
                          input bit poke_mid);
        @(negedge clk);
        a4 = x4; b4 = y4; a32 = x32; b32 = y32; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_mid) begin
            // R9: second start during busy with different operands, must be ignored
            @(negedge clk);
            a4 = ~x4; b4 = y4 + 1'b1; a32 = ~x32; b32 = y32 + 1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (NW) @(negedge clk);
        end else begin
            repeat (NW + 1) @(negedge clk);
        end
    endtask

    initial begin
        // R1: reset state observed while reset held and just after release
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R6 R3 R5 R4: 2 x -3 = -6 walks sub, add, sub, keep with sign-filling shifts
        cur_req = "R6";
        run_op(4'b0010, 4'b1101, 32'd2, 32'hFFFF_FFFD, 0);

        // R8: most negative times most negative
        cur_req = "R8";
        run_op(4'b1000, 4'b1000, 32'h8000_0000, 32'h8000_0000, 0);
        run_op(4'b0111, 4'b1000, 32'h7FFF_FFFF, 32'h8000_0000, 0);
        run_op(4'b1111, 4'b1111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);

        // R9: mid-operation start pulse
        cur_req = "R9";
        run_op(4'b0101, 4'b0110, 32'h1234_5678, 32'h8765_4321, 1);
        run_op(4'b1011, 4'b0111, 32'hDEAD_BEEF, 32'h0000_7FFF, 1);

        // R2 R10 R3 R4 R5: every operand pair at N=4, random at N=32
        cur_req = "R5";
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                run_op(NS'(i), NS'(j), $urandom, $urandom, 0);
            end
        end
        cur_req = "R4";
        for (int k = 0; k < 40; k++) begin
            run_op(NS'($urandom), NS'($urandom), $urandom, {$urandom, 1'b0} >> 1, 0);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule